// File: doc/BRIEF.md
# Pipelined Base-2 Logarithm via Series Expansion

This block turns a normalized mantissa and a binary exponent into a fixed-point base-2 logarithm. The mantissa m arrives as an unsigned value in [1, 2). The exponent e arrives as a signed integer, and it is the floor of log2 of the original operand. The result is e + log2(m).

The fractional part is computed without any table. The block forms the offset d = m - 1.5 and builds d², d³ and d⁴ with successive multiplies. It weights each power by 1/(n·1.5ⁿ) with alternating sign and adds the four terms, which gives ln(m) - ln(1.5). It then scales the sum by 1/ln 2 and adds the constant log2(1.5). Centring the expansion in the middle of the mantissa range keeps the truncation error small at both ends, so no bias correction is applied.

The data path is a nine-stage pipeline with a single valid strobe and no back-pressure. It accepts one operand per clock. All arithmetic runs on signed fixed point with guard bits beyond the output precision, and every product is rounded to nearest.

Top module: `log2t_taylor`

## Requirements
- R1: Every cycle with in_valid high produces exactly one result, with out_valid high exactly 9 clock cycles later. Results come out in input order, whether inputs arrive back to back or with idle gaps.
- R2: out_log is signed two's complement with OF fraction bits. For every mantissa in [1, 2), its integer field out_log[OW-1:OF] equals in_exp sign-extended, so the fraction lies in [0, 1).
- R3: in_mant is unsigned with MF fraction bits and its top bit set. When in_mant equals 3·2^(MF-1) (m = 1.5), out_log equals in_exp·2^OF plus the integer nearest to 2^OF·log2(1.5).
- R4: out_log lies within 3 output LSBs of e + (ln 1.5 + d/1.5 - d²/4.5 + d³/10.125 - d⁴/20.25)/ln 2, where d = m - 1.5, over the whole mantissa range.
- R5: Without any bias term, out_log lies within 0.0025 of the exact e + log2(m) for every m in [1, 2), including both ends of the range.
- R6: out_valid is low while rst is high, and it stays low after reset until an accepted input has had time to reach the output. No result appears that has no matching input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand strobe, one operand per cycle |
| in_mant | input | MF+1 | Mantissa m in [1, 2), unsigned, MF fraction bits |
| in_exp | input | EW | Signed integer part (floor of log2 of the operand) |
| out_valid | output | 1 | Result strobe, 9 cycles after in_valid |
| out_log | output | EW+OF+1 | Signed log2 result, OF fraction bits |

## Verification
The bench builds the block with its defaults: 16 mantissa fraction bits, an 8-bit exponent, 16 output fraction bits and 8 internal guard bits. With these values the rounding of the intermediate products lies far below the 3-LSB bound. This lets the bench tell a real arithmetic fault, such as a wrong sign on one term, a dropped power or a bad constant, apart from rounding noise. The extreme exponents -128 and 127 sit next to mantissas at both ends of [1, 2), so integer-field sign extension and fraction carry are both exercised, and a sweep of 64 mantissas with gaps checks latency and ordering.

// File: rtl/log2t_pkg.sv
package log2t_pkg;

    // Pipeline depth from operand strobe to result strobe.
    localparam int LATENCY = 9;
    // Number of series terms after the constant.
    localparam int NTERMS  = 4;

    // Real value to fixed point with fb fraction bits, rounded to nearest.
    function automatic longint to_fixed(input real v, input int fb);
        return longint'(v * (2.0 ** fb));
    endfunction

    // Magnitude of the weight of term n: 1 / (n * 1.5^n).
    function automatic real term_weight(input int n);
        return 1.0 / (real'(n) * (1.5 ** n));
    endfunction

    // Even-numbered terms enter the sum with a minus sign.
    function automatic bit term_negative(input int n);
        return (n % 2) == 0;
    endfunction

    // log2 of the expansion point.
    function automatic real log2_of_centre();
        return $ln(1.5) / $ln(2.0);
    endfunction

    // Reciprocal of ln 2.
    function automatic real inv_ln2();
        return 1.0 / $ln(2.0);
    endfunction

endpackage

// File: rtl/log2t_mulrnd.sv
// Signed fixed-point multiply, rounded to nearest, result kept at width W.
module log2t_mulrnd #(
    parameter int W  = 26,
    parameter int FB = 24
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FB - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic [PW-W-1:0]      unused_hi;

    always_comb begin
        prod = PW'(a) * PW'(b);
        rnd  = (prod + HALF) >>> FB;
    end

    assign y         = rnd[W-1:0];
    assign unused_hi = rnd[PW-1:W];
endmodule

// File: rtl/log2t_powers.sv
// Stages 1..4: offset from the centre, then d^2, d^3, d^4, one multiply per stage.
module log2t_powers #(
    parameter int MF = 16,
    parameter int EW = 8,
    parameter int FB = 24,
    parameter int DW = FB + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_i,
    input  logic [MF:0]          mant_i,
    input  logic [EW-1:0]        exp_i,
    output logic                 v_o,
    output logic [EW-1:0]        exp_o,
    output logic signed [DW-1:0] pw_o [log2t_pkg::NTERMS]
);
    import log2t_pkg::*;

    localparam logic signed [DW-1:0] CENTRE = DW'(3) <<< (FB - 1);

    logic signed [DW-1:0] mant_fx;
    logic signed [DW-1:0] off_nx;
    logic signed [DW-1:0] pr   [1:NTERMS][1:NTERMS];
    logic signed [DW-1:0] nx   [2:NTERMS];
    logic                 v_q  [1:NTERMS];
    logic [EW-1:0]        e_q  [1:NTERMS];

    always_comb begin
        mant_fx = DW'({1'b0, mant_i}) <<< (FB - MF);
        off_nx  = mant_fx - CENTRE;
    end

    // Next power = previous highest power times d.
    for (genvar s = 2; s <= NTERMS; s++) begin : g_pow
        log2t_mulrnd #(.W(DW), .FB(FB)) mul_i (
            .a (pr[s-1][s-1]),
            .b (pr[s-1][1]),
            .y (nx[s])
        );
    end

    always_ff @(posedge clk) begin
        pr[1][1] <= off_nx;
        for (int j = 2; j <= NTERMS; j++) pr[1][j] <= '0;
        for (int s = 2; s <= NTERMS; s++) begin
            for (int j = 1; j <= NTERMS; j++) begin
                pr[s][j] <= (j == s) ? nx[s] : pr[s-1][j];
            end
        end
        e_q[1] <= exp_i;
        for (int s = 2; s <= NTERMS; s++) e_q[s] <= e_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 1; s <= NTERMS; s++) v_q[s] <= 1'b0;
        end else begin
            v_q[1] <= v_i;
            for (int s = 2; s <= NTERMS; s++) v_q[s] <= v_q[s-1];
        end
    end

    always_comb begin
        for (int k = 0; k < NTERMS; k++) pw_o[k] = pr[NTERMS][k+1];
    end

    assign v_o   = v_q[NTERMS];
    assign exp_o = e_q[NTERMS];
endmodule

// File: rtl/log2t_series.sv
// Stages 5..7: weight each power, apply alternating signs, add as a tree.
module log2t_series #(
    parameter int EW = 8,
    parameter int FB = 24,
    parameter int DW = FB + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_i,
    input  logic [EW-1:0]        exp_i,
    input  logic signed [DW-1:0] pw_i [log2t_pkg::NTERMS],
    output logic                 v_o,
    output logic [EW-1:0]        exp_o,
    output logic signed [DW-1:0] sum_o
);
    import log2t_pkg::*;

    localparam int NPAIR = NTERMS / 2;

    logic signed [DW-1:0] term_nx [NTERMS];
    logic signed [DW-1:0] term_q  [NTERMS];
    logic signed [DW-1:0] signed_t[NTERMS];
    logic signed [DW-1:0] pair_q  [NPAIR];
    logic signed [DW-1:0] sum_q;
    logic [2:0]           v_q;
    logic [EW-1:0]        e_q [3];

    for (genvar k = 0; k < NTERMS; k++) begin : g_term
        localparam logic signed [DW-1:0] WT = DW'(to_fixed(term_weight(k + 1), FB));
        log2t_mulrnd #(.W(DW), .FB(FB)) mul_i (
            .a (WT),
            .b (pw_i[k]),
            .y (term_nx[k])
        );
        assign signed_t[k] = term_negative(k + 1) ? -term_q[k] : term_q[k];
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NTERMS; k++) term_q[k] <= term_nx[k];
        for (int p = 0; p < NPAIR; p++)  pair_q[p] <= signed_t[2*p] + signed_t[2*p+1];
        sum_q  <= pair_q[0] + pair_q[1];
        e_q[0] <= exp_i;
        e_q[1] <= e_q[0];
        e_q[2] <= e_q[1];
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= {v_q[1:0], v_i};
    end

    assign sum_o = sum_q;
    assign v_o   = v_q[2];
    assign exp_o = e_q[2];
endmodule

// File: rtl/log2t_finish.sv
// Stages 8..9: scale by 1/ln2, add log2(1.5), round to output precision, add exponent.
module log2t_finish #(
    parameter int EW = 8,
    parameter int OF = 16,
    parameter int GB = 8,
    parameter int FB = OF + GB,
    parameter int DW = FB + 2,
    parameter int OW = EW + OF + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_i,
    input  logic [EW-1:0]        exp_i,
    input  logic signed [DW-1:0] sum_i,
    output logic                 v_o,
    output logic signed [OW-1:0] log_o
);
    import log2t_pkg::*;

    localparam logic signed [DW-1:0] K_CENTRE = DW'(to_fixed(log2_of_centre(), FB));
    localparam logic signed [DW-1:0] K_SCALE  = DW'(to_fixed(inv_ln2(), FB));
    localparam logic signed [DW-1:0] HALF_OUT = DW'(1) <<< (GB - 1);

    logic signed [DW-1:0] scaled;
    logic signed [DW-1:0] frac_q;
    logic signed [DW-1:0] frac_rnd;
    logic [EW-1:0]        e_q;
    logic signed [OW-1:0] log_q;
    logic [1:0]           v_q;

    log2t_mulrnd #(.W(DW), .FB(FB)) scale_i (
        .a (sum_i),
        .b (K_SCALE),
        .y (scaled)
    );

    assign frac_rnd = (frac_q + HALF_OUT) >>> GB;

    always_ff @(posedge clk) begin
        frac_q <= K_CENTRE + scaled;
        e_q    <= exp_i;
        log_q  <= (OW'($signed(e_q)) <<< OF) + OW'(frac_rnd);
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= {v_q[0], v_i};
    end

    assign v_o   = v_q[1];
    assign log_o = log_q;
endmodule

// File: rtl/log2t_taylor.sv
module log2t_taylor #(
    parameter int MF = 16,
    parameter int EW = 8,
    parameter int OF = 16,
    parameter int GB = 8,
    localparam int FB = OF + GB,
    localparam int DW = FB + 2,
    localparam int OW = EW + OF + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [MF:0]          in_mant,
    input  logic [EW-1:0]        in_exp,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_log
);
    import log2t_pkg::*;

    logic                 pw_v;
    logic [EW-1:0]        pw_e;
    logic signed [DW-1:0] pw   [NTERMS];
    logic                 sr_v;
    logic [EW-1:0]        sr_e;
    logic signed [DW-1:0] sr_sum;

    log2t_powers #(.MF(MF), .EW(EW), .FB(FB), .DW(DW)) powers_i (
        .clk    (clk),
        .rst    (rst),
        .v_i    (in_valid),
        .mant_i (in_mant),
        .exp_i  (in_exp),
        .v_o    (pw_v),
        .exp_o  (pw_e),
        .pw_o   (pw)
    );

    log2t_series #(.EW(EW), .FB(FB), .DW(DW)) series_i (
        .clk   (clk),
        .rst   (rst),
        .v_i   (pw_v),
        .exp_i (pw_e),
        .pw_i  (pw),
        .v_o   (sr_v),
        .exp_o (sr_e),
        .sum_o (sr_sum)
    );

    log2t_finish #(.EW(EW), .OF(OF), .GB(GB), .FB(FB), .DW(DW), .OW(OW)) finish_i (
        .clk   (clk),
        .rst   (rst),
        .v_i   (sr_v),
        .exp_i (sr_e),
        .sum_i (sr_sum),
        .v_o   (out_valid),
        .log_o (out_log)
    );
endmodule

// File: rtl/log2t_taylor_chk.sv
module log2t_taylor_chk #(
    parameter int MF = 16,
    parameter int EW = 8,
    parameter int OF = 16,
    parameter int GB = 8,
    localparam int OW = EW + OF + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [MF:0]          in_mant,
    input logic [EW-1:0]        in_exp,
    input logic                 out_valid,
    input logic signed [OW-1:0] out_log
);
    import log2t_pkg::*;

    localparam logic [MF:0]          CENTRE_IN = (MF + 1)'(3) << (MF - 1);
    localparam logic signed [OW-1:0] K_OUT     = OW'(to_fixed(log2_of_centre(), OF));

    logic [3:0]           warm;
    logic signed [EW:0]   exp_ext;
    logic signed [OW-1:0] exp_scaled;

    assign exp_ext    = (EW + 1)'($signed(in_exp));
    assign exp_scaled = OW'($signed(in_exp)) <<< OF;

    // Edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (rst)                 warm <= '0;
        else if (warm < 4'(LATENCY)) warm <= warm + 4'd1;
    end

    // R1: result strobe follows operand strobe by exactly nine cycles.
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        (warm == 4'(LATENCY)) |-> (out_valid == $past(in_valid, 9)));

    // R2: integer field is the sign-extended exponent.
    a_r2_intpart: assert property (@(posedge clk) disable iff (rst)
        (warm == 4'(LATENCY) && out_valid) |->
        ($signed(out_log[OW-1:OF]) == $past(exp_ext, 9)));

    // R3: the expansion point gives the stored centre constant.
    a_r3_centre: assert property (@(posedge clk) disable iff (rst)
        (warm == 4'(LATENCY) && $past(in_valid, 9) && ($past(in_mant, 9) == CENTRE_IN)) |->
        (out_log == ($past(exp_scaled, 9) + K_OUT)));

    // R6: reset leaves no result strobe behind.
    a_r6_reset_idle: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind log2t_taylor log2t_taylor_chk #(.MF(MF), .EW(EW), .OF(OF), .GB(GB)) chk_i (.*);

// File: tb/log2t_taylor_tb_top.sv
module log2t_taylor_tb_top;
    localparam int MF = 16;
    localparam int EW = 8;
    localparam int OF = 16;
    localparam int GB = 8;
    localparam int OW = EW + OF + 1;
    localparam int LAT = 9;
    localparam real LSB = 1.0 / 65536.0;

    typedef struct {
        real m;
        int  e;
        int  sent;
    } item_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [MF:0]          in_mant = '0;
    logic [EW-1:0]        in_exp = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_log;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    item_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    log2t_taylor #(.MF(MF), .EW(EW), .OF(OF), .GB(GB)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_mant   (in_mant),
        .in_exp    (in_exp),
        .out_valid (out_valid),
        .out_log   (out_log)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%f expected=%f", req, what, act, exp);
        end
    endtask

    function automatic real series_model(input real m, input int e);
        real d;
        real s;
        d = m - 1.5;
        s = $ln(1.5) + d / 1.5 - (d * d) / 4.5 + (d * d * d) / 10.125
            - (d * d * d * d) / 20.25;
        return real'(e) + s / $ln(2.0);
    endfunction

    task automatic send(input int mant, input int e);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_mant  = (MF + 1)'(mant);
        in_exp   = EW'(e);
        it.m     = real'(mant) / 65536.0;
        it.e     = e;
        it.sent  = cyc;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6", "result without input", 1.0, 0.0);
            end else begin
                item_t it;
                real   act;
                real   truth;
                int    ip;
                it    = sb.pop_front();
                act   = $itor(out_log) * LSB;
                truth = real'(it.e) + $ln(it.m) / $ln(2.0);
                ip    = int'(out_log >>> OF);
                // R1: arrival cycle and order
                check(cyc == it.sent + LAT, "R1", "latency", real'(cyc - it.sent), real'(LAT));
                // R2: integer field equals exponent
                check(ip == it.e, "R2", "integer part", real'(ip), real'(it.e));
                // R4: agreement with four-term series
                check((act - series_model(it.m, it.e)) <= 3.0 * LSB &&
                      (series_model(it.m, it.e) - act) <= 3.0 * LSB,
                      "R4", "series model", act, series_model(it.m, it.e));
                // R5: agreement with exact log2
                check((act - truth) <= 0.0025 && (truth - act) <= 0.0025,
                      "R5", "exact log2", act, truth);
                if (it.m == 1.5) begin
                    int k_out;
                    k_out = int'(($ln(1.5) / $ln(2.0)) * 65536.0);
                    // R3: exact centre value
                    check(int'(out_log) == it.e * 65536 + k_out, "R3", "centre value",
                          $itor(out_log), real'(it.e * 65536 + k_out));
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: quiet during reset
        check(out_valid == 1'b0, "R6", "valid during reset", real'(out_valid), 0.0);
        rst = 1'b0;
        idle(14);
        // R6: quiet after reset with no input (monitor flags any strobe)
        check(out_valid == 1'b0, "R6", "valid after reset idle", real'(out_valid), 0.0);

        // Corner mantissas and exponents, back to back.
        send(32'h10000, 0);
        send(32'h18000, 0);
        send(32'h1FFFF, 0);
        send(32'h18000, -3);
        send(32'h10000, 127);
        send(32'h1FFFF, -128);
        send(32'h18000, 127);
        send(32'h18000, -128);
        send(32'h14000, 5);
        send(32'h1C000, -1);
        idle(3);

        // Sweep with periodic gaps.
        for (int i = 0; i < 64; i++) begin
            send(32'h10000 + i * 1024 + 37, (i % 9) - 4);
            if (i % 7 == 6) idle(i % 3 + 1);
        end
        idle(LAT + 6);

        // R1: nothing left in flight
        check(sb.size() == 0, "R1", "results outstanding", real'(sb.size()), 0.0);
        finished = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) check(1'b0, "R1", "watchdog expired", 0.0, 1.0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule